// File: doc/BRIEF.md
# Shared-Bus Serial Configuration Port

This block is a three-wire serial slave (active-low select, serial clock, one data line that is an input except while the block answers a read). It sits behind a display link and holds the link's configuration. The host reaches a 128-entry byte register file and a byte-wide write port into an external colour lookup table through it. All serial pins are brought into the system clock domain and oversampled. The serial clock must run well below the system clock: each SCK phase must last at least four system clocks.

Every transaction opens with a header byte. The header holds a direction bit and then a 7-bit address. A write may stream any number of data bytes after the header, and they go to rising addresses. A read makes the block drive one data byte back. The select line is shared with a second slave. For that reason the block stays locked after reset and after power-down, and it ignores traffic until the host writes an unlock key to a selection register. The whole port is shut while power-down is asserted and while the pixel clock is running.

Top module: `spi_regport`

## Requirements
- R1: Bits are taken on rising SCK edges. The header's first bit is the direction (0 = write, 1 = read), and seven address bits follow, MSB first. Each data byte after the header is sent MSB first. A one-byte write to an unlocked port stores the byte at the given address.
- R2: In a read, `spi_sdo_oe` is 0 while the header is sent. After the eighth rising edge the block drives the addressed byte, MSB first, and moves to the next bit on each falling SCK edge. Over the 16 rising edges the host samples the 8 data bits, and `spi_sdo_oe` falls again after the sixteenth rising edge even if select stays low.
- R3: In a write, every further complete byte while select stays low goes to the next higher address.
- R4: The streaming address stops at 0x7F and does not wrap, so later bytes overwrite 0x7F. At most 256 data bytes per transaction are accepted, and later bytes are dropped.
- R5: The port is locked after reset. Writing 0xFF to address 0x16 unlocks it, and writing any other value there locks it. While locked, writes to any other address are ignored and a read never drives the data line. Address 0x16 reads back the last value written to it.
- R6: The port acts only while `spi_cs_n` is 0, `pd_n` is 1 and `pclk_running` is 0. Bytes sent while the pixel clock runs have no effect.
- R7: In the command register 0x00, bit 0 sets `lut_en` and bit 4 opens the special registers. `lane3_mode` follows bit 2 of register 0x0A. A write to 0x0A is ignored unless command bit 4 is set.
- R8: A write to 0x22 with `lut_en` set gives exactly one `lut_we` pulse. The pulse carries `lut_sel` = bits 1:0 of register 0x21, `lut_idx` = register 0x20 and `lut_wdata` = the byte. Register 0x20 then steps by one and wraps from 0xFF to 0x00. With `lut_en` clear, a write to 0x22 gives no pulse.
- R9: While `pd_n` is 0, all registers clear to zero and the port locks. No `lut_we` pulse is produced.
- R10: After reset every output is 0. A byte left incomplete when `spi_cs_n` rises is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down, active low, synchronous to clk |
| pclk_running | input | 1 | 1 while the pixel clock toggles, synchronous to clk |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Data line, inbound |
| spi_sdo | output | 1 | Data line, outbound value |
| spi_sdo_oe | output | 1 | Drive enable for the data line |
| lut_en | output | 1 | Lookup table enabled |
| lane3_mode | output | 1 | Three-lane link mode selected |
| lut_we | output | 1 | One-cycle table write strobe |
| lut_sel | output | 2 | Colour channel of the table write |
| lut_idx | output | 8 | Entry index of the table write |
| lut_wdata | output | 8 | Byte written to the table |

## Verification
A pin edge needs two synchronizer stages and one edge-detect stage before the frame logic sees it, so the frame logic acts on the third system clock after the edge. A written byte reaches the register file one clock later, and `lut_we` and the mode outputs follow one clock after that. Read data bits change within three clocks of the falling SCK edge. The bench holds each SCK phase for six system clocks. It samples `spi_sdo` and `spi_sdo_oe` just before it raises SCK, and it waits at least eight clocks after raising select before it reads any output or sends the next transaction. Every result is therefore settled when it is sampled.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

  // next streaming address: climbs, then holds at the top entry
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return (a == {ADDR_W{1'b1}}) ? a : a + 1'b1;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           W        = 3,
  parameter int           STAGES   = 2,
  parameter logic [W-1:0] RST_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {STAGES{RST_MASK[i]}};
      else        q <= {q[STAGES-2:0], pin[i]};
    end
    assign lvl[i] = q[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_regport_pkg::*;
#(
  parameter int MAX_BURST = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output wr_req_t           wr_req,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int BC_W = $clog2(DATA_W);
  localparam int BW   = $clog2(MAX_BURST + 1);

  logic [BC_W-1:0]   bit_cnt;
  logic [DATA_W-1:0] shreg, shreg_n, tx_sh;
  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     burst;
  logic              hdr_done, is_rd, tx_active, byte_done;

  assign shreg_n   = {shreg[DATA_W-2:0], sdi};
  assign rd_addr   = shreg_n[ADDR_W-1:0];
  assign byte_done = sck_rise && (bit_cnt == BC_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; shreg <= '0; tx_sh <= '0; addr_q <= '0; burst <= '0;
      hdr_done <= 1'b0; is_rd <= 1'b0; tx_active <= 1'b0; wr_req <= '0;
    end else if (!active) begin
      bit_cnt <= '0; burst <= '0; hdr_done <= 1'b0; is_rd <= 1'b0;
      tx_active <= 1'b0; wr_req.vld <= 1'b0;
    end else begin
      wr_req.vld <= 1'b0;
      if (sck_rise) begin
        shreg   <= shreg_n;
        bit_cnt <= bit_cnt + 1'b1;
      end else if (sck_fall && tx_active && bit_cnt != '0) begin
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
      if (byte_done) begin
        if (!hdr_done) begin
          hdr_done <= 1'b1;
          is_rd    <= shreg_n[DATA_W-1];
          addr_q   <= shreg_n[ADDR_W-1:0];
          if (shreg_n[DATA_W-1]) begin
            tx_active <= 1'b1;
            tx_sh     <= rd_data;
          end
        end else if (!is_rd) begin
          if (burst < BW'(MAX_BURST)) begin
            wr_req <= '{vld: 1'b1, addr: addr_q, data: shreg_n};
            addr_q <= addr_step(addr_q);
            burst  <= burst + 1'b1;
          end
        end else begin
          tx_active <= 1'b0;
        end
      end
    end
  end

  assign sdo_oe = tx_active && unlocked;
  assign sdo    = sdo_oe && tx_sh[DATA_W-1];

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sdo_oe);
  assert_addr_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && $past(hdr_done) && active && $past(active)) |-> (addr_q >= $past(addr_q)));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regport_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SEL_ADDR      = 7'h16,
  parameter logic [ADDR_W-1:0] CMD_ADDR      = 7'h00,
  parameter logic [ADDR_W-1:0] LANE_ADDR     = 7'h0A,
  parameter logic [ADDR_W-1:0] LUT_IDX_ADDR  = 7'h20,
  parameter logic [ADDR_W-1:0] LUT_SEL_ADDR  = 7'h21,
  parameter logic [ADDR_W-1:0] LUT_DATA_ADDR = 7'h22,
  parameter logic [DATA_W-1:0] UNLOCK_KEY    = 8'hFF,
  parameter int                CH_W          = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  wr_req_t           wr_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              unlocked,
  output logic              lut_en,
  output logic              sra_en,
  output logic              lane3_mode,
  output logic              lut_we,
  output logic [CH_W-1:0]   lut_sel,
  output logic [DATA_W-1:0] lut_idx,
  output logic [DATA_W-1:0] lut_wdata
);
  localparam int NREG = 2 ** ADDR_W;

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      unlocked <= 1'b0; lut_we <= 1'b0; lut_sel <= '0; lut_idx <= '0; lut_wdata <= '0;
    end else if (!pd_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      unlocked <= 1'b0; lut_we <= 1'b0;
    end else begin
      lut_we <= 1'b0;
      if (wr_req.vld) begin
        if (wr_req.addr == SEL_ADDR) begin
          regs[SEL_ADDR] <= wr_req.data;
          unlocked       <= (wr_req.data == UNLOCK_KEY);
        end else if (unlocked) begin
          if (wr_req.addr == LANE_ADDR) begin
            if (sra_en) regs[LANE_ADDR] <= wr_req.data;
          end else if (wr_req.addr == LUT_DATA_ADDR) begin
            if (lut_en) begin
              lut_we               <= 1'b1;
              lut_wdata            <= wr_req.data;
              lut_sel              <= regs[LUT_SEL_ADDR][CH_W-1:0];
              lut_idx              <= regs[LUT_IDX_ADDR];
              regs[LUT_IDX_ADDR]   <= regs[LUT_IDX_ADDR] + 1'b1;
            end
          end else begin
            regs[wr_req.addr] <= wr_req.data;
          end
        end
      end
    end
  end

  assign rd_data    = regs[rd_addr];
  assign lut_en     = regs[CMD_ADDR][0];
  assign sra_en     = regs[CMD_ADDR][4];
  assign lane3_mode = regs[LANE_ADDR][2];

  assert_lut_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> lut_en);
  assert_pd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!unlocked && !lut_we && !lut_en && !lane3_mode));
  assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && wr_req.vld && !unlocked && wr_req.addr != SEL_ADDR)
      |=> ($stable(lut_en) && $stable(lane3_mode) && !lut_we));
  assert_lane_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane3_mode) |-> sra_en);
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BURST   = 256,
  parameter int CH_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              pclk_running,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              lut_en,
  output logic              lane3_mode,
  output logic              lut_we,
  output logic [CH_W-1:0]   lut_sel,
  output logic [DATA_W-1:0] lut_idx,
  output logic [DATA_W-1:0] lut_wdata
);
  // pin order in the sync vector: {cs_n, sck, sdi}; cs_n resets high
  logic [2:0]        pin_lvl;
  logic              sck_q, sck_rise, sck_fall, active, unlocked, sra_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  wr_req_t           wr_req;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_MASK(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({spi_cs_n, spi_sck, spi_sdi}), .lvl(pin_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= pin_lvl[1];
  end

  assign sck_rise = pin_lvl[1] && !sck_q;
  assign sck_fall = !pin_lvl[1] && sck_q;
  assign active   = !pin_lvl[2] && pd_n && !pclk_running;

  spi_frame_engine #(.MAX_BURST(MAX_BURST)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi(pin_lvl[0]), .unlocked(unlocked), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_req(wr_req), .sdo(spi_sdo), .sdo_oe(spi_sdo_oe));

  spi_reg_bank #(.CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .wr_req(wr_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .unlocked(unlocked), .lut_en(lut_en), .sra_en(sra_en),
    .lane3_mode(lane3_mode), .lut_we(lut_we), .lut_sel(lut_sel), .lut_idx(lut_idx),
    .lut_wdata(lut_wdata));

  assert_gate_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_running && $past(pclk_running) && $past(pclk_running, 2)) |-> !wr_req.vld && !spi_sdo_oe);
endmodule

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n, pd_n, pclk_running, spi_cs_n, spi_sck, spi_sdi;
  logic spi_sdo, spi_sdo_oe, lut_en, lane3_mode, lut_we;
  logic [1:0] lut_sel;
  logic [7:0] lut_idx, lut_wdata;

  int checks = 0, fails = 0, we_cnt = 0;
  logic [1:0] last_sel;
  logic [7:0] last_idx, last_data;
  logic       post_oe;

  always #5 clk = ~clk;

  spi_regport uut (.*);

  always @(negedge clk) if (lut_we) begin
    we_cnt++; last_sel = lut_sel; last_idx = lut_idx; last_data = lut_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic so, output logic oe);
    spi_sdi = b;
    repeat (HALF) @(negedge clk);
    so = spi_sdo; oe = spi_sdo_oe;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] v, output logic [7:0] rx, output int oe_cnt);
    logic so, oe;
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(v[i], so, oe);
      rx[i] = so;
      if (oe) oe_cnt++;
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rx; int n;
    cs_low();
    spi_byte({1'b0, a}, rx, n);
    spi_byte(d, rx, n);
    cs_high();
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d, output int hdr_oe, output int dat_oe);
    cs_low();
    spi_byte({1'b1, a}, d, hdr_oe);
    spi_byte(8'h00, d, dat_oe);
    repeat (8) @(negedge clk);
    post_oe = spi_sdo_oe;
    cs_high();
  endtask

  function automatic logic [7:0] burst_val(input int k);
    return 8'((k * 3) + 7);
  endfunction

  task automatic t_reset();
    check("R10 reset oe", spi_sdo_oe, 0);
    check("R10 reset outputs", {lut_en, lane3_mode, lut_we}, 0);
  endtask

  task automatic t_locked_read();
    logic [7:0] d; int h, n;
    rd1(7'h05, d, h, n);
    check("R5 locked read drives nothing", n, 0);
  endtask

  task automatic t_basic_rw();
    logic [7:0] d; int h, n;
    wr1(7'h16, 8'hFF);
    wr1(7'h05, 8'hA5);
    rd1(7'h05, d, h, n);
    check("R1 single write/read", d, 8'hA5);
    check("R2 header undriven", h, 0);
    check("R2 data driven 8 bits", n, 8);
    check("R2 release after 16th edge", post_oe, 0);
    wr1(7'h05, 8'h5A);
    rd1(7'h05, d, h, n);
    check("R1 second pattern", d, 8'h5A);
    wr1(7'h05, 8'hA5);
    rd1(7'h16, d, h, n);
    check("R5 select reg readback", d, 8'hFF);
  endtask

  task automatic t_page();
    logic [7:0] rx, d; int n, h;
    cs_low();
    spi_byte({1'b0, 7'h40}, rx, n);
    for (int i = 0; i < 4; i++) spi_byte(8'hC0 + 8'(i), rx, n);
    cs_high();
    for (int i = 0; i < 4; i++) begin
      rd1(7'h40 + 7'(i), d, h, n);
      check("R3 page write", d, 8'hC0 + 8'(i));
    end
  endtask

  task automatic t_saturate();
    logic [7:0] rx, d; int n, h;
    cs_low();
    spi_byte({1'b0, 7'h7D}, rx, n);
    spi_byte(8'h11, rx, n); spi_byte(8'h22, rx, n);
    spi_byte(8'h33, rx, n); spi_byte(8'h44, rx, n);
    cs_high();
    rd1(7'h7E, d, h, n); check("R4 below top", d, 8'h22);
    rd1(7'h7F, d, h, n); check("R4 top holds last", d, 8'h44);
  endtask

  task automatic t_burst_cap();
    logic [7:0] rx, d; int n, h;
    cs_low();
    spi_byte({1'b0, 7'h30}, rx, n);
    for (int k = 0; k < 257; k++) spi_byte(burst_val(k), rx, n);
    cs_high();
    rd1(7'h30, d, h, n); check("R4 burst first", d, burst_val(0));
    rd1(7'h7F, d, h, n); check("R4 257th byte dropped", d, burst_val(255));
  endtask

  task automatic t_lock();
    logic [7:0] d; int h, n;
    wr1(7'h16, 8'h3C);
    wr1(7'h05, 8'h77);
    rd1(7'h05, d, h, n);
    check("R5 locked no drive", n, 0);
    wr1(7'h16, 8'hFF);
    rd1(7'h05, d, h, n);
    check("R5 locked write ignored", d, 8'hA5);
  endtask

  task automatic t_gating();
    logic [7:0] d; int h, n;
    pclk_running = 1'b1;
    wr1(7'h05, 8'h11);
    pclk_running = 1'b0;
    repeat (4) @(negedge clk);
    rd1(7'h05, d, h, n);
    check("R6 pixel clock running blocks", d, 8'hA5);
  endtask

  task automatic t_partial();
    logic [7:0] rx, d; int n, h; logic so, oe;
    cs_low();
    spi_byte({1'b0, 7'h05}, rx, n);
    for (int i = 0; i < 5; i++) spi_bit(1'b1, so, oe);
    cs_high();
    rd1(7'h05, d, h, n);
    check("R10 partial byte discarded", d, 8'hA5);
  endtask

  task automatic t_modes();
    logic [7:0] d; int h, n;
    wr1(7'h0A, 8'h04);
    check("R7 lane write blocked", lane3_mode, 0);
    rd1(7'h0A, d, h, n);
    check("R7 lane reg unchanged", d, 8'h00);
    wr1(7'h00, 8'h11);
    check("R7 lut enable", lut_en, 1);
    wr1(7'h0A, 8'h04);
    check("R7 three-lane set", lane3_mode, 1);
  endtask

  task automatic t_lut();
    logic [7:0] d; int h, n, base;
    wr1(7'h20, 8'hFE);
    wr1(7'h21, 8'h02);
    base = we_cnt;
    wr1(7'h22, 8'h9A);
    check("R8 one pulse", we_cnt - base, 1);
    check("R8 pulse fields", {last_sel, last_idx, last_data}, {2'd2, 8'hFE, 8'h9A});
    wr1(7'h22, 8'h9B);
    check("R8 index step", last_idx, 8'hFF);
    wr1(7'h22, 8'h9C);
    check("R8 index wrap", last_idx, 8'h00);
    rd1(7'h20, d, h, n);
    check("R8 index after wrap", d, 8'h01);
    wr1(7'h00, 8'h10);
    base = we_cnt;
    wr1(7'h22, 8'h55);
    check("R8 disabled no pulse", we_cnt - base, 0);
  endtask

  task automatic t_powerdown();
    logic [7:0] d; int h, n, base;
    wr1(7'h00, 8'h11);
    base = we_cnt;
    pd_n = 1'b0;
    repeat (6) @(negedge clk);
    pd_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 outputs cleared", {lut_en, lane3_mode}, 0);
    check("R9 no table write", we_cnt - base, 0);
    rd1(7'h05, d, h, n);
    check("R9 relocked", n, 0);
    wr1(7'h16, 8'hFF);
    rd1(7'h05, d, h, n);
    check("R9 register cleared", d, 8'h00);
    rd1(7'h20, d, h, n);
    check("R9 index cleared", d, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; pclk_running = 1'b0;
    spi_cs_n = 1'b1; spi_sck = 1'b0; spi_sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_locked_read();
    t_basic_rw();
    t_page();
    t_saturate();
    t_burst_cap();
    t_lock();
    t_gating();
    t_partial();
    t_modes();
    t_lut();
    t_powerdown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule